// File: doc/BRIEF.md
# Two-Size Translation Buffer with Run-Time Superpage Merging

This block caches virtual-to-physical page translations for two page sizes: 4 KB base pages and 16 KB superpages. Base-page translations arrive on a refill port and land in one of two small-page banks. Virtual page number (VPN) bit 0 picks the bank, so only one small bank is enabled on any lookup. The large-page bank is probed on every lookup, and a hit there wins.

After every refill, a merge engine looks at the 16 KB group that the new page belongs to. A merge is allowed only when all four pages of that group are resident in the small banks and their physical page numbers (PPNs) form one aligned run. The engine then writes a single superpage entry and invalidates the four small entries, which frees them for reuse. While the check and the merge run, both the lookup and refill ports show not-ready. A superpage hit returns the superpage base with the low two VPN bits appended.

Top module: `bpt_tlb`

## Requirements
- R1: After reset, both ready outputs are high and every lookup misses (lk_hit = 0).
- R2: A refilled base page hits on lookup with exactly the refilled PPN and lk_large = 0. With lk_valid low, lk_hit is 0.
- R3: VPN bit 0 selects the small bank. VPNs that differ only in bit 0 hold independent translations, and refilling one does not make the other hit.
- R4: A group is eligible when its four VPNs are g*4+o (o = 0..3) and every page o has PPN = base*4+o, with one common base. Once the last such page is refilled, every page of the group hits with lk_large = 1 and lk_ppn = base*4 + vpn[1:0].
- R5: A group does not merge when any page's PPN low two bits differ from its VPN low two bits, when the bases differ, or when a page is missing. Its resident pages keep hitting as small pages with their own PPNs.
- R6: The four small entries consumed by a merge are invalidated. Once the superpage is later evicted, those VPNs miss.
- R7: Each accepted refill is followed by exactly 1 not-ready cycle when no merge happens, and by exactly 1+MERGE_CYC not-ready cycles when a merge happens. While not ready, lk_hit is 0.
- R8: When a VPN hits in both the large bank and a small bank, the large-bank result (lk_large = 1, superpage PPN) is returned.
- R9: A lookup in the same cycle as a refill sees the contents from before the refill.
- R10: A refill of a VPN already resident in a small bank overwrites that entry in place. Otherwise the refill takes the lowest-index invalid entry. In a full bank it takes a round-robin pointer that starts at entry 0 and advances only on such evictions.
- R11: The large bank uses the same policy: the lowest invalid entry first, then a round-robin pointer from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number (4 KB units) |
| lk_ready | output | 1 | Lookups accepted this cycle |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_large | output | 1 | The hit came from the superpage bank |
| lk_ppn | output | PPN_W | Translated physical page number (4 KB units) |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_ready | output | 1 | Refill accepted this cycle |

## Verification
A refill and a lookup can fall in the same cycle, including the refill that completes a mergeable group. The bench provokes this by driving a lookup of the VPN being refilled in that same cycle. It expects a miss in that cycle. It then keeps the lookup asserted through the stall window and expects no hit for exactly 1+MERGE_CYC cycles. Finally it expects a superpage hit whose PPN is computed arithmetically from the group base.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_MERGE = 2'd2
  } merge_state_e;
endpackage

// File: rtl/tlb_small_bank.sv
module tlb_small_bank #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 19,
  parameter int PPN_W   = 20,
  parameter int BANK_ID = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            look_en,
  input  logic [TAG_W-1:0]                look_tag,
  output logic                            look_hit,
  output logic [PPN_W-1:0]                look_ppn,
  input  logic                            wr_en,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic [PPN_W-1:0]                wr_ppn,
  input  logic [TAG_W-2:0]                grp_tag,
  output logic [1:0]                      grp_found,
  output logic [1:0][PPN_W-3:0]           grp_base,
  input  logic                            clr_en
);
  localparam int   IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int   BASE_W   = PPN_W - 2;
  localparam logic BANK_BIT = 1'(BANK_ID);

  logic [ENTRIES-1:0]   valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q [ENTRIES];
  logic [PPN_W-1:0]     ppn_q [ENTRIES];
  logic [IDX_W-1:0]     rr_q, rr_d;
  logic [ENTRIES-1:0]   look_vec, wr_hit_vec;
  logic [1:0][ENTRIES-1:0] grp_vec;
  logic [IDX_W-1:0]     wr_idx;
  logic                 wr_use_rr;

  // per-entry comparators
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign look_vec[e]   = valid_q[e] && (tag_q[e] == look_tag);
    assign wr_hit_vec[e] = valid_q[e] && (tag_q[e] == wr_tag);
    for (genvar h = 0; h < 2; h++) begin : g_half
      // page offset {h, BANK_BIT} of the group, PPN low bits must equal that offset
      assign grp_vec[h][e] = valid_q[e] && (tag_q[e] == {grp_tag, 1'(h)})
                             && (ppn_q[e][1:0] == {1'(h), BANK_BIT});
    end
  end

  always_comb begin
    look_hit = 1'b0;
    look_ppn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (look_en && look_vec[e]) begin
        look_hit = 1'b1;
        look_ppn = look_ppn | ppn_q[e];
      end
    end
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      grp_found[h] = |grp_vec[h];
      grp_base[h]  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (grp_vec[h][e]) grp_base[h] = grp_base[h] | ppn_q[e][PPN_W-1:2];
      end
    end
  end

  // victim choice: resident tag, else lowest invalid, else round robin
  always_comb begin
    wr_idx    = rr_q;
    wr_use_rr = 1'b1;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_q[e]) begin
        wr_idx    = IDX_W'(e);
        wr_use_rr = 1'b0;
      end
    end
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_hit_vec[e]) begin
        wr_idx    = IDX_W'(e);
        wr_use_rr = 1'b0;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (clr_en) begin
      valid_d = valid_q & ~(grp_vec[0] | grp_vec[1]);
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      if (wr_use_rr) rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  logic unused_base_w;
  assign unused_base_w = (BASE_W == 0);
endmodule

// File: rtl/tlb_large_bank.sv
module tlb_large_bank #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 18,
  parameter int BASE_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_en,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_hit,
  output logic [BASE_W-1:0] look_base,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [BASE_W-1:0] wr_base
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [BASE_W-1:0]  base_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic [ENTRIES-1:0] look_vec, wr_hit_vec;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_use_rr;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign look_vec[e]   = valid_q[e] && (tag_q[e] == look_tag);
    assign wr_hit_vec[e] = valid_q[e] && (tag_q[e] == wr_tag);
  end

  always_comb begin
    look_hit  = 1'b0;
    look_base = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (look_en && look_vec[e]) begin
        look_hit  = 1'b1;
        look_base = look_base | base_q[e];
      end
    end
  end

  always_comb begin
    wr_idx    = rr_q;
    wr_use_rr = 1'b1;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_q[e]) begin
        wr_idx    = IDX_W'(e);
        wr_use_rr = 1'b0;
      end
    end
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_hit_vec[e]) begin
        wr_idx    = IDX_W'(e);
        wr_use_rr = 1'b0;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      if (wr_use_rr) rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      base_q[wr_idx] <= wr_base;
    end
  end
endmodule

// File: rtl/tlb_merge_ctl.sv
module tlb_merge_ctl
  import tlb_pkg::*;
#(
  parameter int GRP_W     = 18,
  parameter int BASE_W    = 18,
  parameter int MERGE_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_fire,
  input  logic [GRP_W-1:0]       fill_grp,
  input  logic [1:0]             b0_found,
  input  logic [1:0]             b1_found,
  input  logic [1:0][BASE_W-1:0] b0_base,
  input  logic [1:0][BASE_W-1:0] b1_base,
  output logic                   busy,
  output logic [GRP_W-1:0]       grp,
  output logic                   commit,
  output logic [BASE_W-1:0]      commit_base
);
  localparam int CNT_W = $clog2(MERGE_CYC + 1);

  merge_state_e       state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [GRP_W-1:0]   grp_q;
  logic               grp_en;
  logic               eligible;

  assign eligible = (&b0_found) && (&b1_found)
                    && (b0_base[1] == b0_base[0])
                    && (b1_base[0] == b0_base[0])
                    && (b1_base[1] == b0_base[0]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    grp_en  = 1'b0;
    commit  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fill_fire) begin
          state_d = ST_CHECK;
          grp_en  = 1'b1;
        end
      end
      ST_CHECK: begin
        if (eligible) begin
          state_d = ST_MERGE;
          cnt_d   = CNT_W'(MERGE_CYC - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_MERGE: begin
        if (cnt_q == '0) begin
          commit  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (grp_en) grp_q <= fill_grp;
  end

  assign busy        = (state_q != ST_IDLE);
  assign grp         = grp_q;
  assign commit_base = b0_base[0];
endmodule

// File: rtl/bpt_tlb.sv
module bpt_tlb #(
  parameter int VPN_W         = 20,
  parameter int PPN_W         = 20,
  parameter int SMALL_ENTRIES = 16,
  parameter int LARGE_ENTRIES = 8,
  parameter int MERGE_CYC     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_ready,
  output logic             lk_hit,
  output logic             lk_large,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             fill_ready
);
  localparam int SM_TAG_W = VPN_W - 1;
  localparam int GRP_W    = VPN_W - 2;
  localparam int BASE_W   = PPN_W - 2;

  logic                        busy, commit, fill_fire, look_go;
  logic [GRP_W-1:0]            grp;
  logic [BASE_W-1:0]           commit_base;
  logic [1:0]                  sm_hit;
  logic [PPN_W-1:0]            sm_ppn [2];
  logic [1:0][1:0]             sm_found;
  logic [1:0][1:0][BASE_W-1:0] sm_base;
  logic                        lg_hit;
  logic [BASE_W-1:0]           lg_base;

  assign fill_fire = fill_valid && !busy;
  assign look_go   = lk_valid && !busy;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tlb_small_bank #(
      .ENTRIES (SMALL_ENTRIES),
      .TAG_W   (SM_TAG_W),
      .PPN_W   (PPN_W),
      .BANK_ID (b)
    ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_en   (look_go && (lk_vpn[0] == 1'(b))),
      .look_tag  (lk_vpn[VPN_W-1:1]),
      .look_hit  (sm_hit[b]),
      .look_ppn  (sm_ppn[b]),
      .wr_en     (fill_fire && (fill_vpn[0] == 1'(b))),
      .wr_tag    (fill_vpn[VPN_W-1:1]),
      .wr_ppn    (fill_ppn),
      .grp_tag   (grp),
      .grp_found (sm_found[b]),
      .grp_base  (sm_base[b]),
      .clr_en    (commit)
    );
  end

  tlb_large_bank #(
    .ENTRIES (LARGE_ENTRIES),
    .TAG_W   (GRP_W),
    .BASE_W  (BASE_W)
  ) large_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_en   (look_go),
    .look_tag  (lk_vpn[VPN_W-1:2]),
    .look_hit  (lg_hit),
    .look_base (lg_base),
    .wr_en     (commit),
    .wr_tag    (grp),
    .wr_base   (commit_base)
  );

  tlb_merge_ctl #(
    .GRP_W     (GRP_W),
    .BASE_W    (BASE_W),
    .MERGE_CYC (MERGE_CYC)
  ) merge_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_fire   (fill_fire),
    .fill_grp    (fill_vpn[VPN_W-1:2]),
    .b0_found    (sm_found[0]),
    .b1_found    (sm_found[1]),
    .b0_base     (sm_base[0]),
    .b1_base     (sm_base[1]),
    .busy        (busy),
    .grp         (grp),
    .commit      (commit),
    .commit_base (commit_base)
  );

  assign lk_ready   = !busy;
  assign fill_ready = !busy;
  assign lk_large   = lg_hit;
  assign lk_hit     = lg_hit || sm_hit[lk_vpn[0]];
  assign lk_ppn     = lg_hit ? {lg_base, lk_vpn[1:0]} : sm_ppn[lk_vpn[0]];
endmodule

// File: rtl/bpt_tlb_chk.sv
module bpt_tlb_chk #(
  parameter int MERGE_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic [1:0] lk_off,
  input logic       lk_ready,
  input logic       lk_hit,
  input logic       lk_large,
  input logic [1:0] lk_ppn_off,
  input logic       fill_valid,
  input logic       fill_ready
);
  localparam int SC_W = $clog2(MERGE_CYC + 3);
  logic [SC_W-1:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt <= '0;
    else if (lk_ready) stall_cnt <= '0;
    else if (stall_cnt != SC_W'(MERGE_CYC + 2)) stall_cnt <= stall_cnt + SC_W'(1);
  end

  p_stall_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= SC_W'(MERGE_CYC + 1));
  p_stall_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |-> !lk_hit);
  p_check_follows_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> !fill_ready);
  p_drop_needs_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_ready) |-> $past(fill_valid && fill_ready));
  p_large_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_large) |-> (lk_ppn_off == lk_off));
  p_idle_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
  p_large_is_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_large |-> lk_hit);
endmodule

bind bpt_tlb bpt_tlb_chk #(.MERGE_CYC(MERGE_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_off     (lk_vpn[1:0]),
  .lk_ready   (lk_ready),
  .lk_hit     (lk_hit),
  .lk_large   (lk_large),
  .lk_ppn_off (lk_ppn[1:0]),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready)
);

// File: tb/bpt_tlb_tb_top.sv
`timescale 1ns/1ps
module bpt_tlb_tb_top;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int MC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_ready, lk_hit, lk_large;
  logic [PW-1:0] lk_ppn;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          fill_ready;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bpt_tlb #(
    .VPN_W(VW), .PPN_W(PW), .SMALL_ENTRIES(4), .LARGE_ENTRIES(2), .MERGE_CYC(MC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_large(lk_large), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ready(fill_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic look(input logic [VW-1:0] v, output logic h, output logic lg,
                      output logic [PW-1:0] p);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vpn   = v;
    #1;
    h  = lk_hit;
    lg = lk_large;
    p  = lk_ppn;
    lk_valid = 1'b0;
  endtask

  // refill; optional lookup in the same cycle and during the stall window
  task automatic do_fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                         input bit with_look, input logic [VW-1:0] lv,
                         output logic same_hit, output int stalls,
                         output logic stall_hit);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = v;
    fill_ppn   = p;
    lk_valid   = with_look;
    lk_vpn     = lv;
    #1;
    same_hit = lk_hit;
    @(negedge clk);
    fill_valid = 1'b0;
    stalls    = 0;
    stall_hit = 1'b0;
    #1;
    while (!lk_ready) begin
      stalls++;
      if (lk_hit) stall_hit = 1'b1;
      @(negedge clk);
      #1;
    end
    lk_valid = 1'b0;
  endtask

  task automatic fill_simple(input logic [VW-1:0] v, input logic [PW-1:0] p,
                             input int exp_stall, input string req);
    logic sh, sth;
    int   st;
    do_fill(v, p, 1'b0, '0, sh, st, sth);
    check(req, st, exp_stall);
  endtask

  task automatic expect_small(input logic [VW-1:0] v, input logic [PW-1:0] p,
                              input string req);
    logic h, lg;
    logic [PW-1:0] q;
    look(v, h, lg, q);
    check(req, {h, lg}, 2'b10);
    check(req, q, p);
  endtask

  task automatic expect_large(input logic [VW-1:0] v, input int base, input string req);
    logic h, lg;
    logic [PW-1:0] q;
    look(v, h, lg, q);
    check(req, {h, lg}, 2'b11);
    check(req, q, base * 4 + v[1:0]);
  endtask

  task automatic expect_miss(input logic [VW-1:0] v, input string req);
    logic h, lg;
    logic [PW-1:0] q;
    look(v, h, lg, q);
    check(req, h, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic sh, sth;
    int   st;
    do_reset();

    // R1: reset state, exhaustive lookup sweep
    check("R1", lk_ready, 1);
    check("R1", fill_ready, 1);
    for (int v = 0; v < 256; v++) expect_miss(VW'(v), "R1");

    // R2: lk_valid low gives no hit
    fill_simple(8'h10, 8'h77, 1, "R7");
    @(negedge clk);
    lk_vpn = 8'h10;
    #1;
    check("R2", lk_hit, 0);
    expect_small(8'h10, 8'h77, "R2");

    // R3: neighbour in the other bank stays independent
    expect_miss(8'h11, "R3");
    fill_simple(8'h11, 8'h22, 1, "R7");
    expect_small(8'h11, 8'h22, "R3");
    expect_small(8'h10, 8'h77, "R3");

    // R10: in-place overwrite
    fill_simple(8'h10, 8'h55, 1, "R10");
    expect_small(8'h10, 8'h55, "R10");
    expect_small(8'h11, 8'h22, "R10");

    // R9: lookup in the refill cycle sees old contents
    do_fill(8'h31, 8'h66, 1'b1, 8'h31, sh, st, sth);
    check("R9", sh, 0);
    expect_small(8'h31, 8'h66, "R9");

    // R10: bank 0 replacement order
    fill_simple(8'h20, 8'h01, 1, "R10");
    fill_simple(8'h30, 8'h02, 1, "R10");
    fill_simple(8'h40, 8'h03, 1, "R10");
    fill_simple(8'h50, 8'h05, 1, "R10");
    expect_miss(8'h10, "R10");
    expect_small(8'h50, 8'h05, "R10");
    expect_small(8'h11, 8'h22, "R10");
    fill_simple(8'h60, 8'h06, 1, "R10");
    expect_miss(8'h20, "R10");
    expect_small(8'h30, 8'h02, "R10");
    expect_small(8'h60, 8'h06, "R10");

    // R4 R6 R7 R11: merge sweep over every group
    do_reset();
    for (int g = 0; g < 64; g++) begin
      int base;
      base = (g * 5 + 3) % 64;
      for (int k = 0; k < 4; k++) begin
        int o;
        o = k ^ (g % 4);
        fill_simple(VW'(g * 4 + o), PW'(base * 4 + o), (k == 3) ? 1 + MC : 1, "R7");
      end
      for (int o = 0; o < 4; o++) expect_large(VW'(g * 4 + o), base, "R4");
      if (g >= 1) expect_large(VW'((g - 1) * 4 + 2), ((g - 1) * 5 + 3) % 64, "R11");
      if (g >= 2) begin
        for (int o = 0; o < 4; o++) expect_miss(VW'((g - 2) * 4 + o), "R6");
      end
    end

    // R5: swapped PPN low bits
    do_reset();
    for (int o = 0; o < 4; o++) fill_simple(VW'(20 + o), PW'(36 + (o ^ 1)), 1, "R5");
    for (int o = 0; o < 4; o++) expect_small(VW'(20 + o), PW'(36 + (o ^ 1)), "R5");
    // R5: one page with a different base
    for (int o = 0; o < 4; o++) fill_simple(VW'(24 + o), PW'((o == 3 ? 44 : 40) + o), 1, "R5");
    for (int o = 0; o < 4; o++) expect_small(VW'(24 + o), PW'((o == 3 ? 44 : 40) + o), "R5");
    // R5: a page missing
    do_reset();
    for (int o = 0; o < 3; o++) fill_simple(VW'(28 + o), PW'(48 + o), 1, "R5");
    for (int o = 0; o < 3; o++) expect_small(VW'(28 + o), PW'(48 + o), "R5");
    expect_miss(8'd31, "R5");

    // R8: large result wins over a later small refill of the same page
    do_reset();
    for (int o = 0; o < 4; o++) fill_simple(VW'(12 + o), PW'(128 + o), (o == 3) ? 1 + MC : 1, "R4");
    fill_simple(8'd13, 8'h99, 1, "R8");
    expect_large(8'd13, 32, "R8");

    // R9 R7: refill completing a group with a lookup of that page
    for (int o = 0; o < 3; o++) fill_simple(VW'(16 + o), PW'(200 + o), 1, "R7");
    do_fill(8'd19, 8'd203, 1'b1, 8'd19, sh, st, sth);
    check("R9", sh, 0);
    check("R7", st, 1 + MC);
    check("R7", sth, 0);
    expect_large(8'd19, 50, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule